// File: doc/BRIEF.md
# Ordered Transaction Commit Sequencer

This block is the per-core engine that commits a finished transaction in a transactional memory that buffers writes locally and detects conflicts only at commit time. The core hands it two bitmasks over the directory slices: the set of directories the transaction read from and the set it wrote to. The engine first asks a single central allocator for an 8-bit transaction number. That number fixes the transaction's place in the global commit order and travels in every message the engine sends.

With the number in hand, the engine walks through five message phases. It polls each written directory until that directory reports it has drained all older committers. It tells every directory outside the write set to pass over this number. It announces the updated lines to the written directories. It checks the read directories for conflicts. Last, it makes the updates permanent with a commit message to every directory the transaction touched.

A failed read check ends the transaction as an abort, and no commit message is sent. In every phase the directories are visited in ascending index order. One message leaves per valid/ready handshake. The outcome reaches the core as a one-cycle commit or abort pulse, together with the transaction number.

Top module: `txn_commit_seq`

## Requirements
- R1: A start pulse while idle raises `id_req`, which holds until a cycle with `id_gnt` high. No message is offered while `id_req` is high. The 8-bit `id_val` sampled on the grant edge appears on `msg_tid` of every later message and on `done_tid`.
- R2: The probe phase sends kind 1 to each write-set directory in ascending order. After each probe the engine waits for a response. A response with `rsp_ok`=0 makes it probe the same directory again, and `rsp_ok`=1 moves it to the next directory.
- R3: After the probes, kind 2 (skip) goes to every directory whose write-set bit is 0, in ascending order.
- R4: After the skips, kind 3 (mark) goes to each write-set directory in ascending order.
- R5: After the marks, kind 4 (read check) goes to each read-set directory in ascending order, and each waits for a response. A response with `rsp_ok`=1 passes that directory.
- R6: If every read check passes, kind 5 (commit) goes to each directory set in either mask, in ascending order. Then `done_commit` is high for exactly one cycle and the engine returns to idle.
- R7: A read-check response with `rsp_ok`=0 stops the transaction. No further message is sent, `done_abort` is high for exactly one cycle, and the engine returns to idle.
- R8: Each accepted handshake is one message. Kind, directory and number stay stable while `msg_valid` is high and `msg_ready` is low. `msg_valid` drops for as long as a probe or read-check response is outstanding.
- R9: A start pulse while busy is ignored, including the masks presented with it. A `rsp_valid` that arrives while no response is outstanding is ignored.
- R10: During and right after reset, `busy`, `id_req`, `msg_valid`, `done_commit` and `done_abort` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a commit with the masks below (taken only when idle) |
| rd_set | input | N_DIR | Read-set directory mask |
| wr_set | input | N_DIR | Write-set directory mask |
| busy | output | 1 | A commit is in progress |
| id_req | output | 1 | Request for a transaction number |
| id_gnt | input | 1 | Allocator grants the number on `id_val` |
| id_val | input | 8 | Granted transaction number |
| msg_valid | output | 1 | Outgoing message is valid |
| msg_ready | input | 1 | Directory network accepts the message |
| msg_kind | output | 3 | 1 probe, 2 skip, 3 mark, 4 read check, 5 commit |
| msg_dir | output | log2(N_DIR) | Target directory index |
| msg_tid | output | 8 | Transaction number carried by the message |
| rsp_valid | input | 1 | Response to the outstanding probe or read check |
| rsp_ok | input | 1 | Probe: older committers drained; read check: no conflict |
| done_commit | output | 1 | One-cycle pulse: transaction committed |
| done_abort | output | 1 | One-cycle pulse: transaction aborted |
| done_tid | output | 8 | Transaction number, valid with the done pulses |

## Verification
All state is registered. A grant, a handshake or a response seen at one rising edge shows on the outputs in the following cycle. An outstanding response blocks `msg_valid` from the edge that accepts the probe until the edge that takes the response. The bench drives every input and samples every output on the falling edge, so each stimulus is applied before the edge that consumes it. Each message is logged in the same falling-edge slot in which the bench raises `msg_ready` against a stable `msg_valid`. The done pulse is checked in the slot where it appears, and checked gone one falling edge later. The logged stream is compared entry by entry with a stream the bench builds from the masks, the retry counts and the conflict mask.

// File: rtl/txn_commit_pkg.sv
`timescale 1ns/1ps
// Shared types for the transaction commit sequencer.
// Assumes: transaction numbers are 8 bits; phase order below is the commit order.
package txn_commit_pkg;

    localparam int TID_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE, PH_TID, PH_PROBE, PH_SKIP, PH_MARK, PH_RCHK, PH_COMMIT, PH_FIN
    } phase_e;

    typedef enum logic [2:0] {
        MK_NONE   = 3'd0,
        MK_PROBE  = 3'd1,
        MK_SKIP   = 3'd2,
        MK_MARK   = 3'd3,
        MK_RCHK   = 3'd4,
        MK_COMMIT = 3'd5
    } msg_kind_e;

    // Phase that follows a message phase (or the number request).
    function automatic phase_e next_phase(phase_e p);
        case (p)
            PH_TID:    return PH_PROBE;
            PH_PROBE:  return PH_SKIP;
            PH_SKIP:   return PH_MARK;
            PH_MARK:   return PH_RCHK;
            PH_RCHK:   return PH_COMMIT;
            PH_COMMIT: return PH_FIN;
            default:   return PH_IDLE;
        endcase
    endfunction

    // Message kind emitted in a phase.
    function automatic msg_kind_e kind_of(phase_e p);
        case (p)
            PH_PROBE:  return MK_PROBE;
            PH_SKIP:   return MK_SKIP;
            PH_MARK:   return MK_MARK;
            PH_RCHK:   return MK_RCHK;
            PH_COMMIT: return MK_COMMIT;
            default:   return MK_NONE;
        endcase
    endfunction

    // Phases whose messages wait for a directory response.
    function automatic logic needs_reply(phase_e p);
        return (p == PH_PROBE) || (p == PH_RCHK);
    endfunction

endpackage

// File: rtl/dir_pick.sv
`timescale 1ns/1ps
// Lowest-index picker: returns the smallest set bit of a directory mask.
// Assumes: N_DIR >= 2; purely combinational, depth grows linearly with N_DIR.
module dir_pick #(
    parameter int N_DIR = 8,
    parameter int IDX_W = 3
) (
    input  logic [N_DIR-1:0] mask,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    logic [N_DIR-1:0] lower_set;
    logic [N_DIR-1:0] first_hot;

    assign lower_set[0] = 1'b0;

    // Ripple a "some lower bit is set" flag upward across the mask.
    generate
        for (genvar g = 1; g < N_DIR; g++) begin : g_chain
            assign lower_set[g] = lower_set[g-1] | mask[g-1];
        end
    endgenerate

    assign first_hot = mask & ~lower_set;
    assign any       = |mask;

    // Encode the single hot bit to an index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N_DIR; i++) begin
            if (first_hot[i]) idx = idx | IDX_W'(i);
        end
    end

endmodule

// File: rtl/phase_target.sv
`timescale 1ns/1ps
// Maps a phase to the directory set it must visit, given the latched masks.
// Assumes: masks are stable for the whole transaction.
module phase_target
    import txn_commit_pkg::*;
#(
    parameter int N_DIR = 8
) (
    input  phase_e           ph,
    input  logic [N_DIR-1:0] rd_mask,
    input  logic [N_DIR-1:0] wr_mask,
    output logic [N_DIR-1:0] target
);

    // Select the visiting set for the requested phase.
    always_comb begin
        case (ph)
            PH_PROBE:  target = wr_mask;
            PH_SKIP:   target = ~wr_mask;
            PH_MARK:   target = wr_mask;
            PH_RCHK:   target = rd_mask;
            PH_COMMIT: target = rd_mask | wr_mask;
            default:   target = '0;
        endcase
    end

endmodule

// File: rtl/commit_fsm.sv
`timescale 1ns/1ps
// Commit control: obtains a transaction number, then drains one remaining-
// directory mask per phase, one message per handshake, lowest index first.
// Assumes: at most one response outstanding; responses arrive only after the
// accepted probe or read check; the picker and target map are outside.
module commit_fsm
    import txn_commit_pkg::*;
#(
    parameter int N_DIR = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [N_DIR-1:0] rd_set,
    input  logic [N_DIR-1:0] wr_set,
    input  logic             id_gnt,
    input  logic [TID_W-1:0] id_val,
    input  logic             msg_ready,
    input  logic             rsp_valid,
    input  logic             rsp_ok,
    input  logic             pick_any,
    input  logic [IDX_W-1:0] pick_idx,
    input  logic [N_DIR-1:0] load_mask,
    output phase_e           load_ph,
    output logic [N_DIR-1:0] rem_mask,
    output logic [N_DIR-1:0] rd_q,
    output logic [N_DIR-1:0] wr_q,
    output logic             busy,
    output logic             id_req,
    output logic             msg_valid,
    output logic [2:0]       msg_kind,
    output logic [IDX_W-1:0] msg_dir,
    output logic [TID_W-1:0] msg_tid,
    output logic             done_commit,
    output logic             done_abort,
    output logic [TID_W-1:0] done_tid
);

    phase_e           ph_q;
    logic             wait_q;
    logic             abort_q;
    logic [TID_W-1:0] tid_q;
    logic             msg_phase;

    assign msg_phase = (ph_q == PH_PROBE) || (ph_q == PH_SKIP) || (ph_q == PH_MARK)
                    || (ph_q == PH_RCHK) || (ph_q == PH_COMMIT);

    // Phase to preload when the current one empties.
    assign load_ph = next_phase(ph_q);

    // Port-level view of the current state.
    assign busy        = (ph_q != PH_IDLE);
    assign id_req      = (ph_q == PH_TID);
    assign msg_valid   = msg_phase && pick_any && !wait_q;
    assign msg_kind    = kind_of(ph_q);
    assign msg_dir     = pick_idx;
    assign msg_tid     = tid_q;
    assign done_commit = (ph_q == PH_FIN) && !abort_q;
    assign done_abort  = (ph_q == PH_FIN) && abort_q;
    assign done_tid    = tid_q;

    // Phase sequencing, mask draining, response wait and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q     <= PH_IDLE;
            wait_q   <= 1'b0;
            abort_q  <= 1'b0;
            tid_q    <= '0;
            rem_mask <= '0;
            rd_q     <= '0;
            wr_q     <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (start) begin
                        rd_q    <= rd_set;
                        wr_q    <= wr_set;
                        abort_q <= 1'b0;
                        ph_q    <= PH_TID;
                    end
                end
                PH_TID: begin
                    if (id_gnt) begin
                        tid_q    <= id_val;
                        rem_mask <= load_mask;
                        ph_q     <= load_ph;
                    end
                end
                PH_FIN: begin
                    ph_q <= PH_IDLE;
                end
                default: begin
                    if (!pick_any) begin
                        rem_mask <= load_mask;
                        ph_q     <= load_ph;
                    end else if (wait_q) begin
                        if (rsp_valid) begin
                            wait_q <= 1'b0;
                            if (rsp_ok) begin
                                rem_mask[pick_idx] <= 1'b0;
                            end else if (ph_q == PH_RCHK) begin
                                abort_q  <= 1'b1;
                                rem_mask <= '0;
                                ph_q     <= PH_FIN;
                            end
                        end
                    end else if (msg_ready) begin
                        if (needs_reply(ph_q)) wait_q <= 1'b1;
                        else rem_mask[pick_idx] <= 1'b0;
                    end
                end
            endcase
        end
    end

    // R1: the number request is held until granted.
    assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        id_req && !id_gnt |=> id_req);

    // R1: no message while the number is still outstanding.
    assert_quiet_before_id_R1: assert property (@(posedge clk) disable iff (!rst_n)
        id_req |-> !msg_valid);

    // R8: an offered message keeps its fields until accepted.
    assert_msg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_kind)
                                    && $stable(msg_dir) && $stable(msg_tid));

    // R8: an accepted probe or read check silences the port the next cycle.
    assert_wait_after_query_R8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_ready && (msg_kind == 3'd1 || msg_kind == 3'd4) |=> !msg_valid);

    // R6: commit result is a single-cycle pulse followed by idle.
    assert_commit_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_commit |=> !done_commit && !done_abort && !busy);

    // R7: abort result is a single-cycle pulse, no message, then idle.
    assert_abort_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_abort |=> !done_abort && !msg_valid && !busy);

    // R7: an abort is only ever the consequence of a read check.
    assert_abort_from_rchk_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_abort) |-> $past(ph_q) == PH_RCHK);

    // R9: latched masks cannot change while a commit is running.
    assert_masks_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(rd_q) && $stable(wr_q));

endmodule

// File: rtl/txn_commit_seq.sv
`timescale 1ns/1ps
// Ordered transaction commit sequencer (top).
// Wires the commit control to the lowest-index picker and the phase target map.
// Assumes: the allocator and directories follow the valid/ready and
// single-outstanding-response rules described on the ports.
module txn_commit_seq
    import txn_commit_pkg::*;
#(
    parameter int N_DIR = 8,
    localparam int IDX_W = (N_DIR > 1) ? $clog2(N_DIR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [N_DIR-1:0] rd_set,
    input  logic [N_DIR-1:0] wr_set,
    output logic             busy,
    output logic             id_req,
    input  logic             id_gnt,
    input  logic [7:0]       id_val,
    output logic             msg_valid,
    input  logic             msg_ready,
    output logic [2:0]       msg_kind,
    output logic [IDX_W-1:0] msg_dir,
    output logic [7:0]       msg_tid,
    input  logic             rsp_valid,
    input  logic             rsp_ok,
    output logic             done_commit,
    output logic             done_abort,
    output logic [7:0]       done_tid
);

    phase_e           load_ph;
    logic [N_DIR-1:0] load_mask;
    logic [N_DIR-1:0] rem_mask;
    logic [N_DIR-1:0] rd_q;
    logic [N_DIR-1:0] wr_q;
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;

    commit_fsm #(.N_DIR(N_DIR), .IDX_W(IDX_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .rd_set      (rd_set),
        .wr_set      (wr_set),
        .id_gnt      (id_gnt),
        .id_val      (id_val),
        .msg_ready   (msg_ready),
        .rsp_valid   (rsp_valid),
        .rsp_ok      (rsp_ok),
        .pick_any    (pick_any),
        .pick_idx    (pick_idx),
        .load_mask   (load_mask),
        .load_ph     (load_ph),
        .rem_mask    (rem_mask),
        .rd_q        (rd_q),
        .wr_q        (wr_q),
        .busy        (busy),
        .id_req      (id_req),
        .msg_valid   (msg_valid),
        .msg_kind    (msg_kind),
        .msg_dir     (msg_dir),
        .msg_tid     (msg_tid),
        .done_commit (done_commit),
        .done_abort  (done_abort),
        .done_tid    (done_tid)
    );

    dir_pick #(.N_DIR(N_DIR), .IDX_W(IDX_W)) u_pick (
        .mask (rem_mask),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    phase_target #(.N_DIR(N_DIR)) u_tgt (
        .ph      (load_ph),
        .rd_mask (rd_q),
        .wr_mask (wr_q),
        .target  (load_mask)
    );

endmodule

// File: tb/txn_commit_seq_test.sv
`timescale 1ns/1ps
module txn_commit_seq_test;

    localparam int N  = 8;
    localparam int IW = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [N-1:0]  rd_set = '0, wr_set = '0;
    logic          busy, id_req, msg_valid, done_commit, done_abort;
    logic          id_gnt = 1'b0, msg_ready = 1'b0, rsp_valid = 1'b0, rsp_ok = 1'b0;
    logic [7:0]    id_val = '0;
    logic [2:0]    msg_kind;
    logic [IW-1:0] msg_dir;
    logic [7:0]    msg_tid, done_tid;

    txn_commit_seq #(.N_DIR(N)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_set(rd_set), .wr_set(wr_set),
        .busy(busy), .id_req(id_req), .id_gnt(id_gnt), .id_val(id_val),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
        .msg_dir(msg_dir), .msg_tid(msg_tid), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
        .done_commit(done_commit), .done_abort(done_abort), .done_tid(done_tid)
    );

    int total = 0, bad = 0;
    int retry_cfg[N];
    int left[N];
    int log_n, exp_n;
    logic [2:0]    log_k[128], exp_k[128];
    logic [IW-1:0] log_d[128], exp_d[128];
    logic [7:0]    log_t[128];
    logic [7:0]    next_id = 8'h11;
    logic [7:0]    exp_tid;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic string req_of(input logic [2:0] k);
        case (k)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic exp_push(input logic [2:0] k, input int d);
        exp_k[exp_n] = k;
        exp_d[exp_n] = IW'(d);
        exp_n++;
    endtask

    // Expected stream: probes with retries, skips, marks, read checks, commits.
    task automatic build_exp(input logic [N-1:0] rd, input logic [N-1:0] wr,
                             input logic [N-1:0] cf, output bit ab);
        exp_n = 0;
        ab = 1'b0;
        for (int d = 0; d < N; d++) if (wr[d]) for (int r = 0; r <= retry_cfg[d]; r++) exp_push(3'd1, d);
        for (int d = 0; d < N; d++) if (!wr[d]) exp_push(3'd2, d);
        for (int d = 0; d < N; d++) if (wr[d]) exp_push(3'd3, d);
        for (int d = 0; d < N && !ab; d++) if (rd[d]) begin
            exp_push(3'd4, d);
            if (cf[d]) ab = 1'b1;
        end
        if (!ab) for (int d = 0; d < N; d++) if (rd[d] | wr[d]) exp_push(3'd5, d);
    endtask

    task automatic run_txn(input logic [N-1:0] rd, input logic [N-1:0] wr,
                           input logic [N-1:0] cf, input bit poke);
        bit            exp_ab, seen, g_commit, g_abort;
        int            cnt, bad_i;
        logic [2:0]    pend_k;
        logic [IW-1:0] pend_d;
        logic [7:0]    g_tid;
        build_exp(rd, wr, cf, exp_ab);
        for (int d = 0; d < N; d++) left[d] = retry_cfg[d];
        log_n = 0; cnt = 0; seen = 0; pend_k = 0; pend_d = 0;
        g_commit = 0; g_abort = 0; g_tid = 0;
        @(negedge clk);
        start = 1'b1; rd_set = rd; wr_set = wr;
        @(negedge clk);
        for (int cyc = 0; cyc < 3000 && !seen; cyc++) begin
            start = 1'b0; id_gnt = 1'b0; msg_ready = 1'b0; rsp_valid = 1'b0; rsp_ok = 1'b0;
            if (done_commit || done_abort) begin
                seen = 1; g_commit = done_commit; g_abort = done_abort; g_tid = done_tid;
            end else begin
                // R9 stimulus: a second start with other masks while busy.
                if (poke && cyc == 1) begin
                    start = 1'b1; rd_set = ~rd; wr_set = ~wr;
                end
                if (cnt > 0) begin
                    cnt--;
                    if (cnt == 0) begin
                        rsp_valid = 1'b1;
                        if (pend_k == 3'd1) begin
                            if (left[pend_d] > 0) begin rsp_ok = 1'b0; left[pend_d]--; end
                            else rsp_ok = 1'b1;
                        end else rsp_ok = !cf[pend_d];
                    end
                end else if ($urandom % 4 == 0) begin
                    // R9 stimulus: stray response while none is outstanding.
                    rsp_valid = 1'b1; rsp_ok = 1'($urandom % 2);
                end
                if (id_req && $urandom % 3 == 0) begin
                    id_gnt = 1'b1; id_val = next_id; exp_tid = next_id; next_id = next_id + 8'd37;
                end
                if (msg_valid && $urandom % 3 != 0) begin
                    msg_ready = 1'b1;
                    if (log_n < 128) begin
                        log_k[log_n] = msg_kind; log_d[log_n] = msg_dir; log_t[log_n] = msg_tid;
                        log_n++;
                    end
                    if (msg_kind == 3'd1 || msg_kind == 3'd4) begin
                        cnt = 1 + int'($urandom % 2); pend_k = msg_kind; pend_d = msg_dir;
                    end
                end
                @(negedge clk);
            end
        end
        start = 1'b0; id_gnt = 1'b0; msg_ready = 1'b0; rsp_valid = 1'b0;
        chk(seen, "R6", "transaction finished (watchdog)", int'(seen), 1);
        chk(g_abort == exp_ab && g_commit == !exp_ab, exp_ab ? "R7" : "R6",
            "result abort flag", int'(g_abort), int'(exp_ab));
        chk(g_tid == exp_tid, "R1", "done_tid", g_tid, exp_tid);
        bad_i = -1;
        for (int i = 0; i < exp_n && i < log_n; i++)
            if (bad_i < 0 && (log_k[i] != exp_k[i] || log_d[i] != exp_d[i])) bad_i = i;
        if (bad_i >= 0)
            chk(0, req_of(exp_k[bad_i]), "message kind*16+dir",
                int'(log_k[bad_i]) * 16 + int'(log_d[bad_i]), int'(exp_k[bad_i]) * 16 + int'(exp_d[bad_i]));
        else
            chk(log_n == exp_n, exp_ab ? "R7" : "R6", "message count", log_n, exp_n);
        bad_i = -1;
        for (int i = 0; i < log_n; i++) if (bad_i < 0 && log_t[i] != exp_tid) bad_i = i;
        chk(bad_i < 0, "R1", "msg_tid on every message",
            bad_i < 0 ? int'(exp_tid) : int'(log_t[bad_i]), exp_tid);
        if (poke) chk(bad_i < 0 && log_n == exp_n, "R9", "start while busy ignored", log_n, exp_n);
        @(negedge clk);
        chk(!done_commit && !done_abort && !busy, exp_ab ? "R7" : "R6",
            "pulse one cycle then idle", int'(done_commit | done_abort | busy), 0);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk(!msg_valid && !id_req && !busy, "R9", "quiet after finish",
                int'(msg_valid | id_req | busy), 0);
        end
    endtask

    // Global watchdog ending a hung run as a failure.
    int wd = 0;
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 190000) begin
            bad++; total++;
            $display("FAIL R6 watchdog expired actual=%0d expected=%0d", wd, 190000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int d = 0; d < N; d++) retry_cfg[d] = 0;
        repeat (3) @(negedge clk);
        chk(!busy && !id_req && !msg_valid && !done_commit && !done_abort, "R10",
            "outputs in reset", int'(busy | id_req | msg_valid | done_commit | done_abort), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !id_req && !msg_valid && !done_commit && !done_abort, "R10",
            "outputs after reset", int'(busy | id_req | msg_valid | done_commit | done_abort), 0);

        // Directed: empty masks, only skips then commit pulse (R3, R6).
        run_txn(8'h00, 8'h00, 8'h00, 0);
        // Directed: all directories, retries on the end slices (R2, R4, R6).
        retry_cfg[0] = 2; retry_cfg[7] = 3;
        run_txn(8'hff, 8'hff, 8'h00, 0);
        retry_cfg[0] = 0; retry_cfg[7] = 0;
        // Directed: read only, no probes or marks (R5).
        run_txn(8'h0f, 8'h00, 8'h00, 0);
        // Directed: conflict on the second read check (R7).
        run_txn(8'h24, 8'h81, 8'h20, 0);
        // Directed: conflict on the first read check (R7).
        run_txn(8'h01, 8'h10, 8'h01, 0);
        // Directed: start while busy (R9).
        retry_cfg[2] = 1;
        run_txn(8'h5a, 8'h3c, 8'h00, 1);
        retry_cfg[2] = 0;

        // Random mix of masks, retries and conflicts (R1 to R9).
        for (int t = 0; t < 80; t++) begin
            logic [N-1:0] r, w, c;
            r = N'($urandom); w = N'($urandom);
            c = ($urandom % 3 == 0) ? (N'($urandom) & N'($urandom)) : '0;
            for (int d = 0; d < N; d++) retry_cfg[d] = ($urandom % 4 == 0) ? int'($urandom % 3) : 0;
            run_txn(r, w, c, ($urandom % 8 == 0));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule